// File: doc/BRIEF.md
# SPI EEPROM Page-Write Controller

This block is the slave-side engine behind the page-program command of a serial EEPROM. It watches chip select, serial clock and serial data in, synchronizes them into the system clock domain, and decodes a frame made of a one-byte opcode, a 16-bit address and one or more data bytes, all sent most significant bit first in SPI mode 0. Data bytes are collected in a page-sized staging buffer. The write position wraps inside the page, and each buffer slot records whether it received a byte.

When chip select is released, a gate decides whether the frame becomes a write. The frame must end cleanly on a byte boundary with at least one data byte, the write-enable latch must be set, no self-timed cycle may be running, and the addressed page must lie outside the region locked by the two block-protect inputs. An accepted frame starts a self-timed cycle of a fixed number of system clocks. During that cycle the filled slots are copied into the internal byte array. The busy flag is high for the whole cycle, and the write-enable latch clears when the cycle ends. The serial output is never driven. A side read port exposes the array contents.

Top module: `spi_page_writer`

## Requirements
- R1: A frame of opcode 8'h02, a 16-bit address and one data byte, all MSB first and sampled on rising serial clock edges, writes that byte to array location address mod array depth when chip select returns high.
- R2: A frame is discarded when chip select rises with a partial byte pending, or before the first data byte has been completed. No busy cycle starts in either case.
- R3: Successive data bytes go to slots (start + k) mod 128 within the 128-byte page that holds the start address. A later byte replaces an earlier one that landed on the same slot.
- R4: The write-enable latch is set by a one-cycle pulse on `wel_set` and cleared when the self-timed cycle ends. A frame that arrives while the latch is clear writes nothing.
- R5: A frame whose chip select fell while the busy flag was high writes nothing, even if the flag and the latch are set again by the time the frame ends.
- R6: Protect code `bp` locks part of the array: 0 locks nothing, 1 the top quarter, 2 the top half and 3 everything. A frame addressed to a locked page writes nothing and leaves the latch set.
- R7: An accepted frame raises `wip` within a few clocks of the chip select rising. `wip` then stays high for exactly TW_CYCLES clocks before returning low.
- R8: Only the page slots that received a byte in the accepted frame change. Every other array location keeps its value.
- R9: `sdo_oe` stays low at all times, so the serial output remains high-impedance.
- R10: A frame whose opcode is not 8'h02 writes nothing and starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI serial clock, idle low |
| mosi | input | 1 | SPI serial data in |
| sdo_oe | output | 1 | Serial output enable, always low |
| wel_set | input | 1 | One-cycle pulse that sets the write-enable latch |
| bp | input | 2 | Block-protect code |
| wel | output | 1 | Write-enable latch state |
| wip | output | 1 | Self-timed write cycle in progress |
| rd_addr | input | MEM_ADDR_W | Array read address |
| rd_data | output | 8 | Array byte at rd_addr |

## Verification
The bound checker watches the acceptance gate on every cycle: no acceptance without the latch, while busy or on a locked page. It also checks that `wip` follows each acceptance, lasts exactly TW_CYCLES clocks and leaves the latch clear, and that array writes happen only inside the busy window. Framing faults, page wrap with overwrite, the busy-at-start rejection, the protect decode over every page and the untouched neighbouring bytes can only be shown by the bench's scenarios. For these the bench compares the whole array against its own model after each transaction.

// File: rtl/spw_pkg.sv
package spw_pkg;

  localparam logic [7:0] OPC_PAGE_WRITE = 8'h02;

  typedef enum logic [1:0] {
    PH_OPCODE,
    PH_ADDR,
    PH_DATA,
    PH_DROP
  } phase_t;

  // Slot of the k-th data byte inside a page of page_bytes entries.
  function automatic int unsigned wrap_slot(input int unsigned start,
                                            input int unsigned k,
                                            input int unsigned page_bytes);
    return (start + k) % page_bytes;
  endfunction

  // Locked region from the protect code and the two top address bits.
  function automatic logic region_locked(input logic [1:0] code,
                                         input logic [1:0] top2);
    case (code)
      2'd0:    return 1'b0;
      2'd1:    return top2 == 2'b11;
      2'd2:    return top2[1];
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/spw_sync.sv
module spw_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_pin,
  input  logic sclk_pin,
  input  logic mosi_pin,
  output logic sel,
  output logic sel_fall,
  output logic sel_rise,
  output logic edge_up,
  output logic mosi_s
);
  logic [2:0] cs_p;
  logic [2:0] ck_p;
  logic [1:0] d_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p <= 3'b111;
      ck_p <= 3'b000;
      d_p  <= 2'b00;
    end else begin
      cs_p <= {cs_p[1:0], cs_n_pin};
      ck_p <= {ck_p[1:0], sclk_pin};
      d_p  <= {d_p[0], mosi_pin};
    end
  end

  assign sel      = !cs_p[1];
  assign sel_fall = cs_p[2] && !cs_p[1];
  assign sel_rise = !cs_p[2] && cs_p[1];
  assign edge_up  = !ck_p[2] && ck_p[1];
  assign mosi_s   = d_p[1];
endmodule

// File: rtl/spw_frame_rx.sv
module spw_frame_rx #(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 128,
  localparam int PAGE_LOG2 = $clog2(PAGE_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel,
  input  logic                 sel_fall,
  input  logic                 sel_rise,
  input  logic                 edge_up,
  input  logic                 mosi_s,
  output logic                 byte_done,
  output logic                 data_we,
  output logic [PAGE_LOG2-1:0] data_pos,
  output logic [7:0]           data_byte,
  output logic [ADDR_W-1:0]    frame_addr,
  output logic                 frame_ok
);
  import spw_pkg::*;

  phase_t               phase;
  logic [6:0]           sh;
  logic [2:0]           bit_cnt;
  logic                 addr_second;
  logic                 got_data;
  logic [PAGE_LOG2-1:0] offs;
  logic [7:0]           full;

  assign full      = {sh, mosi_s};
  assign byte_done = sel && edge_up && (bit_cnt == 3'd7);
  assign data_we   = byte_done && (phase == PH_DATA);
  assign data_byte = full;
  assign data_pos  = PAGE_LOG2'(wrap_slot(32'(frame_addr[PAGE_LOG2-1:0]),
                                          32'(offs), PAGE_BYTES));
  assign frame_ok  = sel_rise && (phase == PH_DATA) && got_data &&
                     (bit_cnt == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_DROP;
      sh          <= '0;
      bit_cnt     <= '0;
      addr_second <= 1'b0;
      got_data    <= 1'b0;
      offs        <= '0;
      frame_addr  <= '0;
    end else if (sel_fall) begin
      phase       <= PH_OPCODE;
      bit_cnt     <= '0;
      addr_second <= 1'b0;
      got_data    <= 1'b0;
      offs        <= '0;
    end else if (sel && edge_up) begin
      sh      <= full[6:0];
      bit_cnt <= bit_cnt + 3'd1;
      if (byte_done) begin
        case (phase)
          PH_OPCODE: phase <= (full == OPC_PAGE_WRITE) ? PH_ADDR : PH_DROP;
          PH_ADDR: begin
            frame_addr  <= ADDR_W'({frame_addr, full});
            addr_second <= 1'b1;
            if (addr_second) phase <= PH_DATA;
          end
          PH_DATA: begin
            got_data <= 1'b1;
            offs     <= offs + 1'b1;
          end
          default: phase <= PH_DROP;
        endcase
      end
    end
  end
endmodule

// File: rtl/spw_page_buf.sv
module spw_page_buf #(
  parameter int PAGE_BYTES = 128,
  localparam int PAGE_LOG2 = $clog2(PAGE_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 we,
  input  logic [PAGE_LOG2-1:0] wpos,
  input  logic [7:0]           wdata,
  input  logic [PAGE_LOG2-1:0] rpos,
  output logic [7:0]           rdata,
  output logic                 rvalid
);
  logic [7:0]            slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] filled;

  always_ff @(posedge clk) begin
    if (we) slot_q[wpos] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      filled <= '0;
    else if (clear)  filled <= '0;
    else if (we)     filled[wpos] <= 1'b1;
  end

  assign rdata  = slot_q[rpos];
  assign rvalid = filled[rpos];
endmodule

// File: rtl/spw_commit.sv
module spw_commit #(
  parameter int TW_CYCLES  = 200,
  parameter int PAGE_BYTES = 128,
  parameter int ADDR_W     = 10,
  localparam int PAGE_LOG2 = $clog2(PAGE_BYTES),
  localparam int CNT_W     = $clog2(TW_CYCLES + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [ADDR_W-1:0]           start_addr,
  output logic                        busy,
  output logic                        finish,
  output logic                        step,
  output logic [PAGE_LOG2-1:0]        slot,
  output logic [ADDR_W-PAGE_LOG2-1:0] page_hi
);
  logic [CNT_W-1:0] cnt;

  assign finish = busy && (cnt == CNT_W'(TW_CYCLES - 1));
  assign step   = busy && (cnt < CNT_W'(PAGE_BYTES));
  assign slot   = cnt[PAGE_LOG2-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      page_hi <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      cnt     <= '0;
      page_hi <= start_addr[ADDR_W-1:PAGE_LOG2];
    end else if (busy) begin
      if (finish) busy <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_page_writer.sv
module spi_page_writer #(
  parameter int MEM_ADDR_W = 10,
  parameter int PAGE_BYTES = 128,
  parameter int TW_CYCLES  = 200,
  localparam int PAGE_LOG2 = $clog2(PAGE_BYTES),
  localparam int MEM_DEPTH = 1 << MEM_ADDR_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  sclk,
  input  logic                  mosi,
  output logic                  sdo_oe,
  input  logic                  wel_set,
  input  logic [1:0]            bp,
  output logic                  wel,
  output logic                  wip,
  input  logic [MEM_ADDR_W-1:0] rd_addr,
  output logic [7:0]            rd_data
);
  import spw_pkg::*;

  logic sel, sel_fall, sel_rise, edge_up, mosi_s;
  logic rx_byte, rx_we, ev_frame_ok;
  logic [PAGE_LOG2-1:0]            rx_pos, cm_slot;
  logic [7:0]                      rx_byte_val, buf_rdata;
  logic [MEM_ADDR_W-1:0]           frame_addr;
  logic [MEM_ADDR_W-PAGE_LOG2-1:0] cm_page;
  logic buf_rvalid, cm_step, cm_finish;
  logic busy_seen;
  logic ev_accept, ev_locked, ev_mem_we;
  logic [7:0] mem [MEM_DEPTH];

  spw_sync u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n), .sclk_pin(sclk),
    .mosi_pin(mosi), .sel(sel), .sel_fall(sel_fall), .sel_rise(sel_rise),
    .edge_up(edge_up), .mosi_s(mosi_s)
  );

  spw_frame_rx #(.ADDR_W(MEM_ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_rx (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sel_fall(sel_fall),
    .sel_rise(sel_rise), .edge_up(edge_up), .mosi_s(mosi_s),
    .byte_done(rx_byte), .data_we(rx_we), .data_pos(rx_pos),
    .data_byte(rx_byte_val), .frame_addr(frame_addr), .frame_ok(ev_frame_ok)
  );

  spw_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .clear(sel_fall && !wip),
    .we(rx_we && !busy_seen), .wpos(rx_pos), .wdata(rx_byte_val),
    .rpos(cm_slot), .rdata(buf_rdata), .rvalid(buf_rvalid)
  );

  spw_commit #(.TW_CYCLES(TW_CYCLES), .PAGE_BYTES(PAGE_BYTES),
               .ADDR_W(MEM_ADDR_W)) u_commit (
    .clk(clk), .rst_n(rst_n), .start(ev_accept), .start_addr(frame_addr),
    .busy(wip), .finish(cm_finish), .step(cm_step), .slot(cm_slot),
    .page_hi(cm_page)
  );

  // Rejection gate: framing, latch, busy at either end, protection.
  assign ev_locked = region_locked(bp, frame_addr[MEM_ADDR_W-1 -: 2]);
  assign ev_accept = ev_frame_ok && !busy_seen && wel && !wip && !ev_locked;
  assign ev_mem_we = cm_step && buf_rvalid;
  assign sdo_oe    = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_seen <= 1'b0;
      wel       <= 1'b0;
    end else begin
      if (sel_fall)       busy_seen <= wip;
      if (cm_finish)      wel <= 1'b0;
      else if (wel_set)   wel <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= 8'h00;
    end else if (ev_mem_we) begin
      mem[{cm_page, cm_slot}] <= buf_rdata;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/spw_checker.sv
module spw_checker #(
  parameter int TW_CYCLES = 200
) (
  input logic clk,
  input logic rst_n,
  input logic ev_accept,
  input logic ev_locked,
  input logic ev_mem_we,
  input logic wip,
  input logic wel
);
  logic [31:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   run_len <= '0;
    else if (wip) run_len <= run_len + 32'd1;
    else          run_len <= '0;
  end

  AST_ACCEPT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> wel); // R4
  AST_ACCEPT_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> !wip); // R5
  AST_ACCEPT_NOT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> !ev_locked); // R6
  AST_WIP_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> wip); // R7
  AST_WIP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> (run_len == 32'(TW_CYCLES))); // R7
  AST_WEL_CLEARED_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel); // R4
  AST_WRITE_INSIDE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mem_we |-> wip); // R8
endmodule

bind spi_page_writer spw_checker #(.TW_CYCLES(TW_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_accept(ev_accept), .ev_locked(ev_locked),
  .ev_mem_we(ev_mem_we), .wip(wip), .wel(wel)
);

// File: tb/spi_page_writer_tb_top.sv
module spi_page_writer_tb_top;
  localparam int AW = 10;
  localparam int PB = 128;
  localparam int TW = 200;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, wel_set = 1'b0;
  logic [1:0] bp = 2'd0;
  logic sdo_oe, wel, wip;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;

  spi_page_writer #(.MEM_ADDR_W(AW), .PAGE_BYTES(PB), .TW_CYCLES(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .sdo_oe(sdo_oe), .wel_set(wel_set), .bp(bp), .wel(wel), .wip(wip),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int checks = 0, failures = 0;
  int rises = 0, run = 0, last_run = 0, oe_hits = 0;
  logic wip_d = 1'b0;
  logic [7:0] model [DEPTH];
  logic [7:0] tx [300];

  always @(negedge clk) begin
    if (sdo_oe === 1'b1) oe_hits++;
    if (wip && !wip_d) rises++;
    if (wip) run++;
    else if (run != 0) begin last_run = run; run = 0; end
    wip_d = wip;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_byte(input logic [7:0] b, input int nbits);
    for (int i = 7; i >= 8 - nbits; i--) begin
      mosi = b[i]; tick(4); sclk = 1'b1; tick(4); sclk = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] op, input logic [15:0] a, input int ndata,
                      input int extra, input int addr_bytes);
    cs_n = 1'b0; tick(4);
    spi_byte(op, 8);
    if (addr_bytes > 0) spi_byte(a[15:8], 8);
    if (addr_bytes > 1) spi_byte(a[7:0], 8);
    for (int k = 0; k < ndata; k++) spi_byte(tx[k], 8);
    if (extra > 0) spi_byte(tx[ndata], extra);
    tick(4); cs_n = 1'b1; tick(8);
  endtask

  task automatic fill(input int seed, input int n);
    for (int k = 0; k <= n; k++) tx[k] = 8'((seed * 37 + k * 11 + 1) & 255);
  endtask

  task automatic model_apply(input int a, input int n);
    int base;
    base = (a / PB) * PB;
    for (int k = 0; k < n; k++) model[base + ((a % PB) + k) % PB] = tx[k];
  endtask

  task automatic wait_idle();
    int g;
    g = 0;
    while (wip && g < 5000) begin tick(1); g++; end
    tick(4);
  endtask

  task automatic set_wel();
    @(negedge clk); wel_set = 1'b1; tick(1); wel_set = 1'b0;
  endtask

  task automatic mem_check(input string req);
    int bad, first;
    bad = 0; first = -1;
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = AW'(a); #1;
      if (rd_data !== model[a]) begin bad++; if (first < 0) first = a; end
    end
    check(req, $sformatf("array bytes differing (first at %0d)", first), bad, 0);
    @(negedge clk);
  endtask

  function automatic bit locked(input int code, input int a);
    if (code == 0) return 1'b0;
    if (code == 1) return a >= (DEPTH * 3) / 4;
    if (code == 2) return a >= DEPTH / 2;
    return 1'b1;
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R7 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int r0, a;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    tick(5); rst_n = 1'b1; tick(5);

    // Reset state
    check("R7", "wip after reset", int'(wip), 0);
    check("R4", "wel after reset", int'(wel), 0);
    check("R9", "sdo_oe after reset", int'(sdo_oe), 0);
    mem_check("R8");

    // R1: single byte write, cycle length, latch cleared
    set_wel();
    check("R4", "wel after set pulse", int'(wel), 1);
    r0 = rises; fill(1, 1);
    xfer(8'h02, 16'h0005, 1, 0, 2); model_apply(5, 1);
    wait_idle();
    check("R1", "cycles started by single byte", rises - r0, 1);
    check("R7", "wip high length", last_run, TW);
    check("R4", "wel after cycle", int'(wel), 0);
    mem_check("R1");

    // R4: no latch, write ignored
    r0 = rises; fill(2, 4);
    xfer(8'h02, 16'h0100, 4, 0, 2); wait_idle();
    check("R4", "cycles started without latch", rises - r0, 0);
    mem_check("R4");

    // R3: 130 bytes from slot 126 of page 1, wrap and overwrite
    set_wel(); r0 = rises; fill(3, 130);
    xfer(8'h02, 16'h00FE, 130, 0, 2); model_apply(254, 130);
    wait_idle();
    check("R3", "cycles for wrapped page", rises - r0, 1);
    check("R7", "wip high length after long page", last_run, TW);
    mem_check("R3");
    mem_check("R8");

    // R2: framing faults
    set_wel(); r0 = rises;
    fill(4, 2); xfer(8'h02, 16'h0200, 1, 3, 2); wait_idle();
    fill(5, 2); xfer(8'h02, 16'h0200, 0, 0, 2); wait_idle();
    fill(6, 3); xfer(8'h02, 16'h0200, 2, 5, 2); wait_idle();
    fill(7, 2); xfer(8'h02, 16'h0200, 0, 0, 1); wait_idle();
    check("R2", "cycles started by bad framing", rises - r0, 0);
    check("R2", "wel kept after discarded frames", int'(wel), 1);
    mem_check("R2");

    // R10: wrong opcode
    r0 = rises; fill(8, 2);
    xfer(8'h03, 16'h0210, 2, 0, 2); wait_idle();
    check("R10", "cycles started by wrong opcode", rises - r0, 0);
    mem_check("R10");

    // R5: frame started while busy is rejected even if ready at its end
    r0 = rises; fill(9, 1);
    xfer(8'h02, 16'h0030, 1, 0, 2); model_apply(48, 1);
    fill(10, 6);
    fork
      xfer(8'h02, 16'h0040, 6, 0, 2);
      begin tick(300); set_wel(); end
    join
    wait_idle();
    check("R5", "cycles for busy overlap", rises - r0, 1);
    check("R5", "wel still set after rejected frame", int'(wel), 1);
    mem_check("R5");

    // R6: sweep protect codes over every page
    for (int code = 0; code < 4; code++) begin
      bp = 2'(code);
      for (int pg = 0; pg < DEPTH / PB; pg++) begin
        a = pg * PB + pg * 3 + code;
        set_wel(); r0 = rises; fill(20 + code * 8 + pg, 2);
        xfer(8'h02, 16'(a), 2, 0, 2);
        if (!locked(code, a)) model_apply(a, 2);
        wait_idle();
        check("R6", $sformatf("cycles bp=%0d page=%0d", code, pg),
              rises - r0, locked(code, a) ? 0 : 1);
        if (locked(code, a))
          check("R6", "wel kept on locked page", int'(wel), 1);
      end
      mem_check("R6");
    end
    bp = 2'd0;

    check("R9", "cycles with sdo_oe high", oe_hits, 0);
    finish_run();
  end
endmodule